// File: doc/BRIEF.md
# Buffer Descriptor Ring Walker

This block is the hardware half of a pair of circular descriptor rings, one for transmit and one for receive. Each ring lives in a small flop-based descriptor store. Every entry holds an ownership bit, a wrap flag, two frame flags, a byte length and a buffer pointer. Software fills and recycles entries through a single word-wide access port. The walkers hand entries back to software by clearing the ownership bit.

The transmit walker starts when software kicks it. It walks entries that software has marked ready and raises a request carrying each buffer's pointer, length and flags. When the data path reports the buffer sent, it clears the ready bit and moves on. It parks at the first entry that is not ready, and stays there until the next kick.

The receive walker stores the length and status of each arriving frame into the current empty entry and then clears the empty bit. It tracks whether the current entry is usable. That flag is refreshed only after a fill or when software restarts the receive side. A frame that finds no usable entry is dropped and reported as an overrun.

In both rings the index moves one entry at a time. It returns to entry 0 after an entry that carries the wrap flag, or after the last entry of the store.

Top module: `bd_ring_walker`

## Requirements
- R1: After reset both indices are 0, every stored descriptor word reads 0, and tx_req, rx_avail, rx_overrun and tx_len_err are all low.
- R2: A descriptor word of the default widths is laid out as follows. Bit 30 is ownership (ready for transmit, empty for receive). Bit 29 is wrap. Bit 28 is last-in-frame. Bit 27 is the flag bit (append CRC for transmit, error for receive). Bits 26:16 are the length and bits 15:0 are the buffer pointer. sw_ring 0 selects the transmit store and 1 selects the receive store.
- R3: A transmit entry that is ready and has a valid length produces tx_req, with its pointer, length, last flag and CRC flag. tx_req holds until tx_done. After tx_done the entry's ready bit reads 0 and every other field is unchanged.
- R4: Each walker handles entries strictly in sequence. Its index goes from i to i+1, or to 0 after an entry with the wrap flag or after the last entry of the store. An entry beyond a wrap flag is never touched.
- R5: On reaching a transmit entry that is not ready, the transmit walker parks there. It makes no request, even if software later sets ready, until tx_kick is pulsed.
- R6: A ready transmit entry with length 0 or above 1500 is not requested. Its ready bit is cleared, tx_len_err pulses for one cycle, and the walk continues. A length of exactly 1500 is requested normally.
- R7: A frame accepted while rx_avail is high is written into the current receive entry. Ownership goes to 0, the length is stored as given (CRC bytes included), and the last and error flags are stored. The wrap flag and the pointer are kept.
- R8: A frame presented while rx_avail is low changes no descriptor and no index. rx_overrun is high for the one cycle after it.
- R9: rx_avail is low after reset and right after each fill. It is reloaded from the current entry's empty bit only one cycle after a fill, or on rx_restart. An entry that software returns without a restart stays unusable.
- R10: rx_buf_ptr shows the buffer pointer of the current receive entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sw_we | input | 1 | Software descriptor write strobe |
| sw_ring | input | 1 | Store select: 0 transmit, 1 receive |
| sw_idx | input | 3 | Entry index for software access |
| sw_wdata | input | 31 | Descriptor word to write |
| sw_rdata | output | 31 | Descriptor word at sw_ring/sw_idx |
| tx_kick | input | 1 | Restarts a parked transmit walker |
| tx_req | output | 1 | Transmit buffer request |
| tx_ptr | output | 16 | Buffer pointer of the requested entry |
| tx_len | output | 11 | Byte length of the requested entry |
| tx_last | output | 1 | Last-in-frame flag of the requested entry |
| tx_crc | output | 1 | Append-CRC flag of the requested entry |
| tx_done | input | 1 | Requested buffer has been sent |
| tx_len_err | output | 1 | Pulse: ready entry rejected for its length |
| rx_restart | input | 1 | Re-polls the current receive entry |
| rx_frm_valid | input | 1 | A received frame completes this cycle |
| rx_frm_len | input | 11 | Frame length including CRC bytes |
| rx_frm_last | input | 1 | Frame ends in this buffer |
| rx_frm_err | input | 1 | Frame carries an error |
| rx_avail | output | 1 | Current receive entry is usable |
| rx_buf_ptr | output | 16 | Buffer pointer of the current receive entry |
| rx_overrun | output | 1 | Pulse: a frame was dropped |

## Verification
The hardest state to reach is a receive entry that is empty in storage but still unusable to the walker. Software has handed it back, but no restart has re-polled it. The stimulus fills both receive entries and forces one overrun on the wrapped index. It then writes the empty bit back without a restart and presents a frame, which must still be dropped. For transmit, the tricky cases are a wrap-bounded ring with a ready entry placed just past the wrap flag, and a run of bad-length entries in front of a good one. A full lap of the store with no wrap flag at all is also driven. The scoreboard queue then proves the request order.

// File: rtl/bdr_pkg.sv
package bdr_pkg;

   typedef enum logic [1:0] {
      TX_PARK = 2'd0,
      TX_POLL = 2'd1,
      TX_SEND = 2'd2
   } tx_state_e;

   // own, wrap, last and flag bits sit above length and pointer
   function automatic int desc_width(input int len_w, input int ptr_w);
      return len_w + ptr_w + 4;
   endfunction

endpackage

// File: rtl/bdr_desc_ram.sv
module bdr_desc_ram #(
   parameter int DEPTH = 8,
   parameter int DW    = 31,
   parameter int AW    = 3,
   parameter int IW    = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          sw_we,
   input  logic [AW-1:0] sw_addr,
   input  logic [DW-1:0] sw_wdata,
   output logic [DW-1:0] sw_rdata,
   input  logic [IW-1:0] hw_addr,
   output logic [DW-1:0] hw_rdata,
   input  logic          hw_we,
   input  logic [DW-1:0] hw_wdata
);

   if (AW < IW) begin : g_bad_aw
      $error("software address narrower than store index");
   end

   logic [DW-1:0] mem [DEPTH];
   logic          sw_in_range;

   assign sw_in_range = ({1'b0, sw_addr} < (AW+1)'(DEPTH));

   // one register per entry; a software write wins over a walker update
   for (genvar e = 0; e < DEPTH; e++) begin : g_entry
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            mem[e] <= '0;
         else if (sw_we && sw_in_range && sw_addr == AW'(e))
            mem[e] <= sw_wdata;
         else if (hw_we && hw_addr == IW'(e))
            mem[e] <= hw_wdata;
      end
   end

   assign sw_rdata = sw_in_range ? mem[sw_addr[IW-1:0]] : '0;
   assign hw_rdata = mem[hw_addr];

endmodule

// File: rtl/bdr_tx_walker.sv
module bdr_tx_walker import bdr_pkg::*; #(
   parameter int LEN_W   = 11,
   parameter int PTR_W   = 16,
   parameter int DEPTH   = 8,
   parameter int MAX_LEN = 1500,
   parameter int DW      = LEN_W + PTR_W + 4,
   parameter int IW      = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             kick,
   input  logic [DW-1:0]    desc,
   output logic [IW-1:0]    idx,
   output logic             upd_we,
   output logic [DW-1:0]    upd_desc,
   output logic             tx_req,
   output logic [PTR_W-1:0] tx_ptr,
   output logic [LEN_W-1:0] tx_len,
   output logic             tx_last,
   output logic             tx_crc,
   input  logic             tx_done,
   output logic             len_err
);

   localparam int LEN_LO = PTR_W;
   localparam int FLAG_B = PTR_W + LEN_W;
   localparam int LAST_B = FLAG_B + 1;
   localparam int WRAP_B = FLAG_B + 2;
   localparam int OWN_B  = FLAG_B + 3;

   tx_state_e     state;
   logic          own, wrap, len_ok;
   logic [IW-1:0] next_idx;

   assign own     = desc[OWN_B];
   assign wrap    = desc[WRAP_B];
   assign tx_ptr  = desc[PTR_W-1:0];
   assign tx_len  = desc[LEN_LO +: LEN_W];
   assign tx_last = desc[LAST_B];
   assign tx_crc  = desc[FLAG_B];
   assign len_ok  = (tx_len != '0) && (tx_len <= LEN_W'(MAX_LEN));
   assign tx_req  = (state == TX_SEND);

   assign next_idx = (wrap || idx == IW'(DEPTH-1)) ? '0 : idx + 1'b1;

   always_comb begin
      upd_desc        = desc;
      upd_desc[OWN_B] = 1'b0;
      upd_we          = (state == TX_POLL && own && !len_ok) ||
                        (state == TX_SEND && tx_done);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= TX_PARK;
         idx     <= '0;
         len_err <= 1'b0;
      end else begin
         len_err <= 1'b0;
         unique case (state)
            TX_PARK: if (kick) state <= TX_POLL;
            TX_POLL: begin
               if (!own) begin
                  state <= TX_PARK;
               end else if (!len_ok) begin
                  len_err <= 1'b1;
                  idx     <= next_idx;
               end else begin
                  state <= TX_SEND;
               end
            end
            TX_SEND: if (tx_done) begin
               idx   <= next_idx;
               state <= TX_POLL;
            end
            default: state <= TX_PARK;
         endcase
      end
   end

   a_r4_tx_step: assert property (@(posedge clk) disable iff (!rst_n)
      (idx != $past(idx)) |-> (idx == '0 || idx == IW'($past(idx) + 1'b1)));

   a_r6_tx_len_valid: assert property (@(posedge clk) disable iff (!rst_n)
      tx_req |-> (tx_len != '0 && tx_len <= LEN_W'(MAX_LEN)));

   a_r3_tx_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_req && !tx_done) |=> tx_req);

   a_r5_tx_park: assert property (@(posedge clk) disable iff (!rst_n)
      (state == TX_PARK && !kick) |=> !tx_req);

endmodule

// File: rtl/bdr_rx_walker.sv
module bdr_rx_walker #(
   parameter int LEN_W = 11,
   parameter int PTR_W = 16,
   parameter int DEPTH = 8,
   parameter int DW    = LEN_W + PTR_W + 4,
   parameter int IW    = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             restart,
   input  logic             frm_valid,
   input  logic [LEN_W-1:0] frm_len,
   input  logic             frm_last,
   input  logic             frm_err,
   input  logic [DW-1:0]    desc,
   output logic [IW-1:0]    idx,
   output logic             upd_we,
   output logic [DW-1:0]    upd_desc,
   output logic             avail,
   output logic [PTR_W-1:0] buf_ptr,
   output logic             overrun
);

   localparam int LEN_LO = PTR_W;
   localparam int FLAG_B = PTR_W + LEN_W;
   localparam int LAST_B = FLAG_B + 1;
   localparam int WRAP_B = FLAG_B + 2;
   localparam int OWN_B  = FLAG_B + 3;

   logic          poll, fill;
   logic [IW-1:0] next_idx;
   logic          unused_fields;

   assign unused_fields = ^{desc[LAST_B], desc[FLAG_B], desc[LEN_LO +: LEN_W]};
   assign buf_ptr  = desc[PTR_W-1:0];
   assign fill     = frm_valid && avail;
   assign next_idx = (desc[WRAP_B] || idx == IW'(DEPTH-1)) ? '0 : idx + 1'b1;
   assign upd_we   = fill;
   assign upd_desc = {1'b0, desc[WRAP_B], frm_last, frm_err, frm_len, buf_ptr};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idx     <= '0;
         avail   <= 1'b0;
         poll    <= 1'b0;
         overrun <= 1'b0;
      end else begin
         overrun <= frm_valid && !avail;
         if (fill) begin
            idx   <= next_idx;
            avail <= 1'b0;
            poll  <= 1'b1;
         end else if (restart || poll) begin
            avail <= desc[OWN_B];
            poll  <= 1'b0;
         end
      end
   end

   a_r8_rx_overrun: assert property (@(posedge clk) disable iff (!rst_n)
      (frm_valid && !avail) |=> (overrun && $stable(idx)));

   a_r9_rx_fill_disarms: assert property (@(posedge clk) disable iff (!rst_n)
      (frm_valid && avail) |=> !avail);

   a_r4_rx_step: assert property (@(posedge clk) disable iff (!rst_n)
      (idx != $past(idx)) |-> (idx == '0 || idx == IW'($past(idx) + 1'b1)));

endmodule

// File: rtl/bd_ring_walker.sv
module bd_ring_walker import bdr_pkg::*; #(
   parameter int LEN_W      = 11,
   parameter int PTR_W      = 16,
   parameter int TX_DEPTH   = 8,
   parameter int RX_DEPTH   = 8,
   parameter int MAX_TX_LEN = 1500,
   parameter int SW_AW      = $clog2((TX_DEPTH > RX_DEPTH) ? TX_DEPTH : RX_DEPTH)
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   sw_we,
   input  logic                   sw_ring,
   input  logic [SW_AW-1:0]       sw_idx,
   input  logic [LEN_W+PTR_W+3:0] sw_wdata,
   output logic [LEN_W+PTR_W+3:0] sw_rdata,
   input  logic                   tx_kick,
   output logic                   tx_req,
   output logic [PTR_W-1:0]       tx_ptr,
   output logic [LEN_W-1:0]       tx_len,
   output logic                   tx_last,
   output logic                   tx_crc,
   input  logic                   tx_done,
   output logic                   tx_len_err,
   input  logic                   rx_restart,
   input  logic                   rx_frm_valid,
   input  logic [LEN_W-1:0]       rx_frm_len,
   input  logic                   rx_frm_last,
   input  logic                   rx_frm_err,
   output logic                   rx_avail,
   output logic [PTR_W-1:0]       rx_buf_ptr,
   output logic                   rx_overrun
);

   localparam int DW    = desc_width(LEN_W, PTR_W);
   localparam int TX_IW = $clog2(TX_DEPTH);
   localparam int RX_IW = $clog2(RX_DEPTH);

   if (TX_DEPTH < 2 || RX_DEPTH < 2) begin : g_bad_depth
      $error("each ring store needs at least two entries");
   end
   if (MAX_TX_LEN < 1 || MAX_TX_LEN >= (1 << LEN_W)) begin : g_bad_max
      $error("transmit length limit does not fit the length field");
   end

   logic [DW-1:0]    tx_sw_rd, rx_sw_rd, tx_cur, rx_cur, tx_upd, rx_upd;
   logic [TX_IW-1:0] tx_idx;
   logic [RX_IW-1:0] rx_idx;
   logic             tx_upd_we, rx_upd_we;

   bdr_desc_ram #(.DEPTH(TX_DEPTH), .DW(DW), .AW(SW_AW)) u_tx_store (
      .clk(clk), .rst_n(rst_n),
      .sw_we(sw_we && !sw_ring), .sw_addr(sw_idx), .sw_wdata(sw_wdata),
      .sw_rdata(tx_sw_rd),
      .hw_addr(tx_idx), .hw_rdata(tx_cur), .hw_we(tx_upd_we), .hw_wdata(tx_upd)
   );

   bdr_desc_ram #(.DEPTH(RX_DEPTH), .DW(DW), .AW(SW_AW)) u_rx_store (
      .clk(clk), .rst_n(rst_n),
      .sw_we(sw_we && sw_ring), .sw_addr(sw_idx), .sw_wdata(sw_wdata),
      .sw_rdata(rx_sw_rd),
      .hw_addr(rx_idx), .hw_rdata(rx_cur), .hw_we(rx_upd_we), .hw_wdata(rx_upd)
   );

   assign sw_rdata = sw_ring ? rx_sw_rd : tx_sw_rd;

   bdr_tx_walker #(.LEN_W(LEN_W), .PTR_W(PTR_W), .DEPTH(TX_DEPTH),
                   .MAX_LEN(MAX_TX_LEN)) u_tx_walk (
      .clk(clk), .rst_n(rst_n), .kick(tx_kick), .desc(tx_cur), .idx(tx_idx),
      .upd_we(tx_upd_we), .upd_desc(tx_upd),
      .tx_req(tx_req), .tx_ptr(tx_ptr), .tx_len(tx_len), .tx_last(tx_last),
      .tx_crc(tx_crc), .tx_done(tx_done), .len_err(tx_len_err)
   );

   bdr_rx_walker #(.LEN_W(LEN_W), .PTR_W(PTR_W), .DEPTH(RX_DEPTH)) u_rx_walk (
      .clk(clk), .rst_n(rst_n), .restart(rx_restart),
      .frm_valid(rx_frm_valid), .frm_len(rx_frm_len), .frm_last(rx_frm_last),
      .frm_err(rx_frm_err), .desc(rx_cur), .idx(rx_idx),
      .upd_we(rx_upd_we), .upd_desc(rx_upd),
      .avail(rx_avail), .buf_ptr(rx_buf_ptr), .overrun(rx_overrun)
   );

endmodule

// File: tb/bd_ring_walker_bench.sv
`timescale 1ns/1ps
module bd_ring_walker_bench;

   logic        clk = 0;
   logic        rst_n = 0;
   logic        sw_we = 0, sw_ring = 0;
   logic [2:0]  sw_idx = 0;
   logic [30:0] sw_wdata = 0;
   logic [30:0] sw_rdata;
   logic        tx_kick = 0, tx_done = 0;
   logic        tx_req, tx_last, tx_crc, tx_len_err;
   logic [15:0] tx_ptr;
   logic [10:0] tx_len;
   logic        rx_restart = 0, rx_frm_valid = 0, rx_frm_last = 0, rx_frm_err = 0;
   logic [10:0] rx_frm_len = 0;
   logic        rx_avail, rx_overrun;
   logic [15:0] rx_buf_ptr;

   int total = 0, failed = 0, sent = 0, ovr_cnt = 0, lerr_cnt = 0;
   logic [63:0] exp_q[$];
   logic [30:0] w;

   always #10 clk = ~clk;

   bd_ring_walker u_bd_ring_walker (
      .clk(clk), .rst_n(rst_n), .sw_we(sw_we), .sw_ring(sw_ring), .sw_idx(sw_idx),
      .sw_wdata(sw_wdata), .sw_rdata(sw_rdata), .tx_kick(tx_kick), .tx_req(tx_req),
      .tx_ptr(tx_ptr), .tx_len(tx_len), .tx_last(tx_last), .tx_crc(tx_crc),
      .tx_done(tx_done), .tx_len_err(tx_len_err), .rx_restart(rx_restart),
      .rx_frm_valid(rx_frm_valid), .rx_frm_len(rx_frm_len), .rx_frm_last(rx_frm_last),
      .rx_frm_err(rx_frm_err), .rx_avail(rx_avail), .rx_buf_ptr(rx_buf_ptr),
      .rx_overrun(rx_overrun)
   );

   function automatic logic [30:0] mk(bit own, bit wrap, bit last, bit flag,
                                      int len, int ptr);
      return {own, wrap, last, flag, 11'(len), 16'(ptr)};
   endfunction

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (act !== exp) begin
         failed++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wr(input bit ring, input int idx, input logic [30:0] word);
      @(negedge clk);
      sw_ring = ring; sw_idx = 3'(idx); sw_wdata = word; sw_we = 1;
      @(negedge clk);
      sw_we = 0;
   endtask

   task automatic rd(input bit ring, input int idx, output logic [30:0] word);
      @(negedge clk);
      sw_ring = ring; sw_idx = 3'(idx);
      #1 word = sw_rdata;
   endtask

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic push_tx(input int ptr, input int len, input bit last, input bit crc);
      exp_q.push_back(64'({crc, last, 11'(len), 16'(ptr)}));
   endtask

   task automatic kick();
      @(negedge clk); tx_kick = 1;
      @(negedge clk); tx_kick = 0;
   endtask

   task automatic restart();
      @(negedge clk); rx_restart = 1;
      @(negedge clk); rx_restart = 0;
   endtask

   task automatic frame(input int len, input bit last, input bit err);
      @(negedge clk);
      rx_frm_valid = 1; rx_frm_len = 11'(len); rx_frm_last = last; rx_frm_err = err;
      @(negedge clk);
      rx_frm_valid = 0;
   endtask

   // scoreboard monitor: compares each request, then answers with tx_done
   always @(negedge clk) begin
      if (tx_req && !tx_done) begin
         if (exp_q.size() == 0)
            chk("R3 unexpected tx request", 64'({tx_crc, tx_last, tx_len, tx_ptr}), 64'hdead);
         else
            chk("R3 tx request fields", 64'({tx_crc, tx_last, tx_len, tx_ptr}),
                exp_q.pop_front());
         sent++;
         tx_done = 1;
      end else begin
         tx_done = 0;
      end
      if (rx_overrun) ovr_cnt++;
      if (tx_len_err) lerr_cnt++;
   end

   initial begin
      #(20 * 150000);
      failed++; total++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", total - failed, total);
      $finish;
   end

   initial begin
      cyc(3);
      rst_n = 1;
      cyc(1);
      // R1 reset state
      chk("R1 tx_req", tx_req, 0);
      chk("R1 rx_avail", rx_avail, 0);
      chk("R1 pulses", {rx_overrun, tx_len_err}, 0);
      rd(0, 0, w); chk("R1 tx entry cleared", w, 0);
      rd(1, 7, w); chk("R1 rx entry cleared", w, 0);

      // R3/R4/R2: three-entry ring bounded by wrap, entry 3 beyond it
      wr(0, 0, mk(1, 0, 1, 1, 64, 16'h1000));
      wr(0, 1, mk(1, 0, 0, 0, 1500, 16'h2000));
      wr(0, 2, mk(1, 1, 1, 0, 60, 16'h3000));
      wr(0, 3, mk(1, 0, 0, 0, 100, 16'h4000));
      push_tx(16'h1000, 64, 1, 1);
      push_tx(16'h2000, 1500, 0, 0);
      push_tx(16'h3000, 60, 1, 0);
      kick();
      cyc(30);
      chk("R4 sends within wrapped ring", sent, 3);
      chk("R6 length 1500 accepted (queue drained)", exp_q.size(), 0);
      rd(0, 3, w); chk("R4 entry beyond wrap untouched", w, mk(1, 0, 0, 0, 100, 16'h4000));
      rd(0, 0, w); chk("R3 R2 ready cleared fields kept", w, mk(0, 0, 1, 1, 64, 16'h1000));
      rd(0, 2, w); chk("R3 wrap kept", w, mk(0, 1, 1, 0, 60, 16'h3000));

      // R5 parked at entry 0: set ready without kick
      wr(0, 0, mk(1, 0, 0, 1, 200, 16'h5000));
      cyc(10);
      chk("R5 no request while parked", sent, 3);
      push_tx(16'h5000, 200, 0, 1);
      kick();
      cyc(10);
      chk("R5 request after kick", sent, 4);

      // R6 bad lengths at 1 and 2, good entry 0 after wrap
      wr(0, 1, mk(1, 0, 0, 0, 0, 16'h2100));
      wr(0, 2, mk(1, 1, 0, 0, 1501, 16'h2200));
      wr(0, 0, mk(1, 0, 1, 1, 40, 16'h6000));
      push_tx(16'h6000, 40, 1, 1);
      kick();
      cyc(20);
      chk("R6 two length errors", lerr_cnt, 2);
      chk("R6 good entry still sent", sent, 5);
      rd(0, 1, w); chk("R6 zero-length entry returned", w, mk(0, 0, 0, 0, 0, 16'h2100));
      rd(0, 2, w); chk("R6 oversize entry returned", w, mk(0, 1, 0, 0, 1501, 16'h2200));

      // R4 full lap without wrap flag: 1..7 then back to 0
      for (int i = 2; i < 8; i++) wr(0, i, mk(1, 0, i[0], 1, 10*i+5, 16'h7000 + 16'h100*i));
      wr(0, 0, mk(1, 0, 0, 1, 5, 16'h7000));
      wr(0, 1, mk(1, 0, 1, 1, 15, 16'h7100));
      for (int i = 1; i < 8; i++) push_tx(16'h7000 + 16'h100*i, 10*i+5, i[0], 1);
      push_tx(16'h7000, 5, 0, 1);
      kick();
      cyc(60);
      chk("R4 lap through last entry", sent, 13);
      chk("R4 lap order (queue drained)", exp_q.size(), 0);

      // receive ring: entries 0,1 with wrap on 1; entry 2 beyond
      wr(1, 0, mk(1, 0, 0, 0, 0, 16'hA000));
      wr(1, 1, mk(1, 1, 0, 0, 0, 16'hB000));
      wr(1, 2, mk(1, 0, 0, 0, 0, 16'hC000));
      frame(80, 1, 0);
      cyc(2);
      chk("R9 parked after reset drops frame", ovr_cnt, 1);
      rd(1, 0, w); chk("R8 dropped frame leaves entry", w, mk(1, 0, 0, 0, 0, 16'hA000));
      restart();
      cyc(1);
      chk("R9 restart arms", rx_avail, 1);
      chk("R10 current pointer", rx_buf_ptr, 16'hA000);
      frame(68, 1, 0);
      cyc(2);
      rd(1, 0, w); chk("R7 first fill", w, mk(0, 0, 1, 0, 68, 16'hA000));
      chk("R9 re-poll after fill", rx_avail, 1);
      chk("R10 pointer advanced", rx_buf_ptr, 16'hB000);
      frame(1522, 0, 1);
      cyc(2);
      rd(1, 1, w); chk("R7 second fill with error", w, mk(0, 1, 0, 1, 1522, 16'hB000));
      chk("R4 rx wrapped onto used entry", rx_avail, 0);
      chk("R10 pointer after wrap", rx_buf_ptr, 16'hA000);
      frame(90, 1, 0);
      cyc(2);
      chk("R8 overrun on used entry", ovr_cnt, 2);
      wr(1, 0, mk(1, 0, 0, 0, 0, 16'hA000));
      frame(90, 1, 0);
      cyc(2);
      chk("R9 returned without restart still drops", ovr_cnt, 3);
      rd(1, 0, w); chk("R9 returned entry unchanged", w, mk(1, 0, 0, 0, 0, 16'hA000));
      restart();
      frame(100, 1, 0);
      cyc(2);
      rd(1, 0, w); chk("R7 fill after restart", w, mk(0, 0, 1, 0, 100, 16'hA000));
      chk("R8 no extra overrun", ovr_cnt, 3);
      rd(1, 2, w); chk("R4 rx entry beyond wrap untouched", w, mk(1, 0, 0, 0, 0, 16'hC000));

      $display("%0d/%0d checks passed", total - failed, total);
      $finish;
   end

endmodule